// File: doc/BRIEF.md
# Host Data Bus Byte-Lane Steering

This block connects a 16-bit host data bus to a RAM port that is organised as an even byte and an odd byte. It decides which host byte lane carries which RAM byte, which lanes the host-side pads may drive, how write data from the host lanes is routed into the two RAM bytes, and when to signal to the host that a 16-bit cycle is being served. Two small configuration registers set this up: a bus control register whose bit 7 turns on 16-bit transfers, and a low address pointer whose bit 0 has two uses. With 16-bit transfers off it is address bit 0 and picks the byte. With them on it becomes the swap control.

The lane order depends on two things: the host bus style (read/write strobes, or direction plus data strobe) and the swap control. CPU and DMA cycles are steered the same way. The only difference is that a DMA cycle never asserts the 16-bit cycle indicator. Host bus style detection and the RAM array itself lie outside the block; both appear as plain inputs. The steering path is combinational. A register write takes effect at the clock edge on which it is sampled.

Top module: `host_lane_steer`

## Requirements
- R1: A write to the bus control register (cfg_wr high at a rising clock edge) loads cfg_wdata bit 7 as the 16-bit mode flag, which is used from that edge on. Reset clears the flag (8-bit mode).
- R2: A pointer write (ptr_wr high at a rising edge) stores ptr_wdata bit 0 in one bit. In 16-bit mode that bit is the swap control. In 8-bit mode it is address bit 0 (0 = even byte, 1 = odd byte). Rewriting only the mode re-interprets the stored bit.
- R3: With host_style = 0 (strobe style) in 16-bit mode, swap 0 puts the even byte on bits 7:0 and the odd byte on bits 15:8. Swap 1 reverses this.
- R4: With host_style = 1 (direction/data-strobe style) in 16-bit mode, swap 0 puts the odd byte on bits 7:0 and the even byte on bits 15:8. Swap 1 reverses this.
- R5: In 8-bit mode, lane_hi_oe is never high, host_rdata bits 15:8 are zero, and bits 7:0 carry the byte chosen by address bit 0.
- R6: lane_lo_oe equals host_rd AND ram_sel. lane_hi_oe is high only when lane_lo_oe is high and 16-bit mode is on.
- R7: io16_n is low exactly when 16-bit mode is on, ram_sel is high, host_rd or host_wr is high, and dma_cyc is low.
- R8: DMA cycles (dma_cyc = 1) use the same lane mapping and output enables as CPU cycles.
- R9: A 16-bit RAM write raises both byte write enables and routes the host lanes to the RAM bytes with the same mapping as R3/R4, so that a write followed by a read gives back the same lanes. An 8-bit RAM write raises only the enable chosen by address bit 0 and takes its data from bits 7:0.
- R10: When ram_sel is low, neither RAM write enable rises and neither lane output enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Bus control register write strobe |
| cfg_wdata | input | 8 | Bus control register write data (bit 7 = 16-bit mode) |
| ptr_wr | input | 1 | Low address pointer write strobe |
| ptr_wdata | input | 8 | Low address pointer write data (bit 0 = address bit 0 / swap) |
| host_style | input | 1 | Detected host bus style: 0 strobe, 1 direction/data-strobe |
| ram_sel | input | 1 | Current cycle targets the RAM |
| dma_cyc | input | 1 | Current cycle is a DMA cycle |
| host_rd | input | 1 | Read cycle active |
| host_wr | input | 1 | Write cycle active |
| host_wdata | input | 16 | Host write data, both lanes |
| ram_rdata_even | input | 8 | RAM even byte read data |
| ram_rdata_odd | input | 8 | RAM odd byte read data |
| host_rdata | output | 16 | Steered read data for the host lanes |
| lane_lo_oe | output | 1 | Drive enable for host bits 7:0 |
| lane_hi_oe | output | 1 | Drive enable for host bits 15:8 |
| ram_wdata_even | output | 8 | Write data to RAM even byte |
| ram_wdata_odd | output | 8 | Write data to RAM odd byte |
| ram_we_even | output | 1 | Write enable, RAM even byte |
| ram_we_odd | output | 1 | Write enable, RAM odd byte |
| io16_n | output | 1 | Active-low 16-bit CPU cycle indicator |

## Verification
Steered read data, output enables, write routing and io16_n are combinational in the cycle signals. They are due in the same cycle as the stimulus, so the bench drives at the falling edge and samples 1 ns later, before the next rising edge. A configuration write is due one rising edge after its strobe. The bench confirms that the old mode still holds before that edge and that the new one applies after it. Every lane-mapping check comes after an explicit pointer write, so no check relies on the value of the swap bit at reset.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  typedef enum logic {
    STYLE_STROBE = 1'b0,
    STYLE_DIRDS  = 1'b1
  } host_style_e;

  // Effective configuration seen by the steering logic.
  typedef struct packed {
    logic wide;   // 16-bit transfers enabled
    logic swap;   // lane swap, meaningful only when wide
    logic addr0;  // byte select, meaningful only when not wide
  } lane_cfg_t;

endpackage

// File: rtl/lane_cfg_regs.sv
module lane_cfg_regs
  import lane_steer_pkg::*;
#(
  parameter int CTL_W    = 8,
  parameter int MODE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CTL_W-1:0] cfg_wdata,
  input  logic             ptr_wr,
  input  logic [CTL_W-1:0] ptr_wdata,
  output logic             wide_q,
  output logic             ptr_bit0_q,
  output lane_cfg_t        cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q     <= 1'b0;
      ptr_bit0_q <= 1'b0;
    end else begin
      if (cfg_wr) wide_q     <= cfg_wdata[MODE_BIT];
      if (ptr_wr) ptr_bit0_q <= ptr_wdata[0];
    end
  end

  // One storage bit, two meanings chosen by the mode flag.
  always_comb begin
    cfg.wide  = wide_q;
    cfg.swap  = wide_q & ptr_bit0_q;
    cfg.addr0 = ~wide_q & ptr_bit0_q;
  end

endmodule

// File: rtl/lane_ctl.sv
module lane_ctl (
  input  logic wide,
  input  logic ram_sel,
  input  logic dma_cyc,
  input  logic host_rd,
  input  logic host_wr,
  output logic lane_lo_oe,
  output logic lane_hi_oe,
  output logic ram_wr_en,
  output logic io16_n
);

  logic ram_rd;
  logic active;

  always_comb begin
    ram_rd     = host_rd & ram_sel;
    active     = (host_rd | host_wr) & ram_sel;
    lane_lo_oe = ram_rd;
    lane_hi_oe = ram_rd & wide;
    ram_wr_en  = host_wr & ram_sel;
    io16_n     = ~(active & wide & ~dma_cyc);
  end

endmodule

// File: rtl/lane_route.sv
module lane_route
  import lane_steer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  lane_cfg_t              cfg,
  input  logic                   host_style,
  input  logic                   ram_wr_en,
  input  logic [2*BYTE_W-1:0]    host_wdata,
  input  logic [BYTE_W-1:0]      ram_rdata_even,
  input  logic [BYTE_W-1:0]      ram_rdata_odd,
  output logic [2*BYTE_W-1:0]    host_rdata,
  output logic [BYTE_W-1:0]      ram_wdata_even,
  output logic [BYTE_W-1:0]      ram_wdata_odd,
  output logic                   ram_we_even,
  output logic                   ram_we_odd
);

  localparam int LANES = 2;

  logic             even_hi;
  logic [LANES-1:0] carries_even;

  // Direction/data-strobe style starts from the opposite order; swap flips it.
  assign even_hi = (host_style == STYLE_DIRDS) ^ cfg.swap;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_lo
      assign carries_even[l] = ~even_hi;
      assign host_rdata[l*BYTE_W +: BYTE_W] =
        cfg.wide ? (carries_even[l] ? ram_rdata_even : ram_rdata_odd)
                 : (cfg.addr0 ? ram_rdata_odd : ram_rdata_even);
    end else begin : g_hi
      assign carries_even[l] = even_hi;
      assign host_rdata[l*BYTE_W +: BYTE_W] =
        cfg.wide ? (carries_even[l] ? ram_rdata_even : ram_rdata_odd)
                 : '0;
    end
  end

  always_comb begin
    if (cfg.wide) begin
      ram_wdata_even = carries_even[1] ? host_wdata[BYTE_W +: BYTE_W]
                                       : host_wdata[0 +: BYTE_W];
      ram_wdata_odd  = carries_even[1] ? host_wdata[0 +: BYTE_W]
                                       : host_wdata[BYTE_W +: BYTE_W];
    end else begin
      ram_wdata_even = host_wdata[0 +: BYTE_W];
      ram_wdata_odd  = host_wdata[0 +: BYTE_W];
    end
    ram_we_even = ram_wr_en & (cfg.wide | ~cfg.addr0);
    ram_we_odd  = ram_wr_en & (cfg.wide |  cfg.addr0);
  end

endmodule

// File: rtl/host_lane_steer.sv
module host_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CTL_W    = 8,
  parameter int MODE_BIT = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CTL_W-1:0]    cfg_wdata,
  input  logic                ptr_wr,
  input  logic [CTL_W-1:0]    ptr_wdata,
  input  logic                host_style,
  input  logic                ram_sel,
  input  logic                dma_cyc,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [2*BYTE_W-1:0] host_wdata,
  input  logic [BYTE_W-1:0]   ram_rdata_even,
  input  logic [BYTE_W-1:0]   ram_rdata_odd,
  output logic [2*BYTE_W-1:0] host_rdata,
  output logic                lane_lo_oe,
  output logic                lane_hi_oe,
  output logic [BYTE_W-1:0]   ram_wdata_even,
  output logic [BYTE_W-1:0]   ram_wdata_odd,
  output logic                ram_we_even,
  output logic                ram_we_odd,
  output logic                io16_n
);

  lane_cfg_t cfg;
  logic      wide_q;
  logic      ptr_bit0_q;
  logic      ram_wr_en;

  lane_cfg_regs #(
    .CTL_W    (CTL_W),
    .MODE_BIT (MODE_BIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .ptr_wr     (ptr_wr),
    .ptr_wdata  (ptr_wdata),
    .wide_q     (wide_q),
    .ptr_bit0_q (ptr_bit0_q),
    .cfg        (cfg)
  );

  lane_ctl u_ctl (
    .wide       (cfg.wide),
    .ram_sel    (ram_sel),
    .dma_cyc    (dma_cyc),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .lane_lo_oe (lane_lo_oe),
    .lane_hi_oe (lane_hi_oe),
    .ram_wr_en  (ram_wr_en),
    .io16_n     (io16_n)
  );

  lane_route #(
    .BYTE_W (BYTE_W)
  ) u_route (
    .cfg            (cfg),
    .host_style     (host_style),
    .ram_wr_en      (ram_wr_en),
    .host_wdata     (host_wdata),
    .ram_rdata_even (ram_rdata_even),
    .ram_rdata_odd  (ram_rdata_odd),
    .host_rdata     (host_rdata),
    .ram_wdata_even (ram_wdata_even),
    .ram_wdata_odd  (ram_wdata_odd),
    .ram_we_even    (ram_we_even),
    .ram_we_odd     (ram_we_odd)
  );

endmodule

// File: rtl/host_lane_steer_chk.sv
module host_lane_steer_chk #(
  parameter int CTL_W    = 8,
  parameter int MODE_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CTL_W-1:0] cfg_wdata,
  input logic             ptr_wr,
  input logic [CTL_W-1:0] ptr_wdata,
  input logic             ram_sel,
  input logic             dma_cyc,
  input logic             host_rd,
  input logic             host_wr,
  input logic             lane_lo_oe,
  input logic             lane_hi_oe,
  input logic             ram_we_even,
  input logic             ram_we_odd,
  input logic             io16_n,
  input logic             wide_q,
  input logic             ptr_bit0_q
);

  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (wide_q == $past(cfg_wdata[MODE_BIT])));  // R1

  AST_PTR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (ptr_bit0_q == $past(ptr_wdata[0])));  // R2

  AST_UPPER_QUIET_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> !lane_hi_oe);  // R5

  AST_UPPER_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    lane_hi_oe |-> (ram_sel && host_rd && lane_lo_oe));  // R6

  AST_IO16_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !io16_n |-> (!dma_cyc && ram_sel && wide_q && (host_rd || host_wr)));  // R7

  AST_WIDE_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && host_wr && ram_sel) |-> (ram_we_even && ram_we_odd));  // R9

  AST_NARROW_WRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_q && host_wr && ram_sel) |-> ($countones({ram_we_even, ram_we_odd}) == 1));  // R9

  AST_IDLE_OFF_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> !(ram_we_even || ram_we_odd || lane_lo_oe || lane_hi_oe));  // R10

endmodule

bind host_lane_steer host_lane_steer_chk #(
  .CTL_W    (CTL_W),
  .MODE_BIT (MODE_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_wdata   (cfg_wdata),
  .ptr_wr      (ptr_wr),
  .ptr_wdata   (ptr_wdata),
  .ram_sel     (ram_sel),
  .dma_cyc     (dma_cyc),
  .host_rd     (host_rd),
  .host_wr     (host_wr),
  .lane_lo_oe  (lane_lo_oe),
  .lane_hi_oe  (lane_hi_oe),
  .ram_we_even (ram_we_even),
  .ram_we_odd  (ram_we_odd),
  .io16_n      (io16_n),
  .wide_q      (wide_q),
  .ptr_bit0_q  (ptr_bit0_q)
);

// File: tb/host_lane_steer_test.sv
module host_lane_steer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        ptr_wr = 1'b0;
  logic [7:0]  ptr_wdata = '0;
  logic        host_style = 1'b0;
  logic        ram_sel = 1'b0;
  logic        dma_cyc = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  ram_rdata_even = 8'hA5;
  logic [7:0]  ram_rdata_odd = 8'h3C;
  logic [15:0] host_rdata;
  logic        lane_lo_oe;
  logic        lane_hi_oe;
  logic [7:0]  ram_wdata_even;
  logic [7:0]  ram_wdata_odd;
  logic        ram_we_even;
  logic        ram_we_odd;
  logic        io16_n;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  host_lane_steer uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .ptr_wr         (ptr_wr),
    .ptr_wdata      (ptr_wdata),
    .host_style     (host_style),
    .ram_sel        (ram_sel),
    .dma_cyc        (dma_cyc),
    .host_rd        (host_rd),
    .host_wr        (host_wr),
    .host_wdata     (host_wdata),
    .ram_rdata_even (ram_rdata_even),
    .ram_rdata_odd  (ram_rdata_odd),
    .host_rdata     (host_rdata),
    .lane_lo_oe     (lane_lo_oe),
    .lane_hi_oe     (lane_hi_oe),
    .ram_wdata_even (ram_wdata_even),
    .ram_wdata_odd  (ram_wdata_odd),
    .ram_we_even    (ram_we_even),
    .ram_we_odd     (ram_we_odd),
    .io16_n         (io16_n)
  );

  // {wide, ptr bit0, style, dma, expected host_rdata, expected hi_oe, expected io16_n}
  // RAM even byte = A5, odd byte = 3C.
  localparam int NV = 9;
  localparam logic [21:0] VEC [NV] = '{
    {4'b1000, 16'h3CA5, 1'b1, 1'b0},  // R3 strobe, no swap
    {4'b1100, 16'hA53C, 1'b1, 1'b0},  // R3 strobe, swapped
    {4'b1010, 16'hA53C, 1'b1, 1'b0},  // R4 dir/ds, no swap
    {4'b1110, 16'h3CA5, 1'b1, 1'b0},  // R4 dir/ds, swapped
    {4'b1001, 16'h3CA5, 1'b1, 1'b1},  // R8 DMA strobe
    {4'b1111, 16'h3CA5, 1'b1, 1'b1},  // R8 DMA dir/ds swapped
    {4'b0000, 16'h00A5, 1'b0, 1'b1},  // R5 narrow even
    {4'b0100, 16'h003C, 1'b0, 1'b1},  // R5 narrow odd
    {4'b0111, 16'h003C, 1'b0, 1'b1}   // R5 R8 narrow DMA odd
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic wide, input logic b0);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = {wide, 7'h00};
    ptr_wr    = 1'b1;
    ptr_wdata = {7'h00, b0};
    @(negedge clk);
    cfg_wr = 1'b0;
    ptr_wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: narrow mode (R1)
    @(negedge clk);
    host_rd = 1'b1; ram_sel = 1'b1;
    #1;
    chk("R1 reset hi_oe", {15'b0, lane_hi_oe}, 16'h0000);
    chk("R1 reset io16_n", {15'b0, io16_n}, 16'h0001);
    chk("R6 reset lo_oe", {15'b0, lane_lo_oe}, 16'h0001);

    // R1 timing: mode applies only after the rising edge
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h80;
    #1;
    chk("R1 before edge io16_n", {15'b0, io16_n}, 16'h0001);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    chk("R1 after edge io16_n", {15'b0, io16_n}, 16'h0000);
    chk("R1 after edge hi_oe", {15'b0, lane_hi_oe}, 16'h0001);
    host_rd = 1'b0; ram_sel = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i][21], VEC[i][20]);
      host_style = VEC[i][19];
      dma_cyc    = VEC[i][18];
      host_rd    = 1'b1;
      ram_sel    = 1'b1;
      #1;
      chk($sformatf("R3 R4 R5 R8 rdata vec %0d", i), host_rdata, VEC[i][17:2]);
      chk($sformatf("R5 R6 hi_oe vec %0d", i), {15'b0, lane_hi_oe}, {15'b0, VEC[i][1]});
      chk($sformatf("R7 io16_n vec %0d", i), {15'b0, io16_n}, {15'b0, VEC[i][0]});
      host_rd = 1'b0;
      dma_cyc = 1'b0;
    end

    // R6: upper lane stays off for non-RAM reads in 16-bit mode
    set_cfg(1'b1, 1'b0);
    host_style = 1'b0; host_rd = 1'b1; ram_sel = 1'b0;
    #1;
    chk("R6 non-RAM hi_oe", {15'b0, lane_hi_oe}, 16'h0000);
    chk("R6 non-RAM lo_oe", {15'b0, lane_lo_oe}, 16'h0000);
    chk("R7 non-RAM io16_n", {15'b0, io16_n}, 16'h0001);
    host_rd = 1'b0;

    // R2: stored bit re-read as swap after a mode-only change
    set_cfg(1'b0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h80;
    @(negedge clk);
    cfg_wr = 1'b0;
    host_style = 1'b0; host_rd = 1'b1; ram_sel = 1'b1;
    #1;
    chk("R2 bit0 becomes swap", host_rdata, 16'hA53C);
    host_rd = 1'b0;

    // R9: 16-bit writes, mapping mirrors reads
    set_cfg(1'b1, 1'b0);
    host_style = 1'b0; host_wr = 1'b1; ram_sel = 1'b1; host_wdata = 16'hBEEF;
    #1;
    chk("R9 strobe even data", {8'h00, ram_wdata_even}, 16'h00EF);
    chk("R9 strobe odd data", {8'h00, ram_wdata_odd}, 16'h00BE);
    chk("R9 wide both we", {14'b0, ram_we_even, ram_we_odd}, 16'h0003);
    chk("R7 cpu write io16_n", {15'b0, io16_n}, 16'h0000);
    host_style = 1'b1;
    #1;
    chk("R9 dirds even data", {8'h00, ram_wdata_even}, 16'h00BE);
    chk("R9 dirds odd data", {8'h00, ram_wdata_odd}, 16'h00EF);
    host_wr = 1'b0;
    set_cfg(1'b1, 1'b1);
    host_wr = 1'b1;
    #1;
    chk("R9 dirds swapped even data", {8'h00, ram_wdata_even}, 16'h00EF);

    // R9: 8-bit write to odd byte
    host_wr = 1'b0;
    set_cfg(1'b0, 1'b1);
    host_wr = 1'b1; host_style = 1'b0;
    #1;
    chk("R9 narrow we", {14'b0, ram_we_even, ram_we_odd}, 16'h0001);
    chk("R9 narrow odd data", {8'h00, ram_wdata_odd}, 16'h00EF);

    // R10: write outside RAM touches nothing
    host_wr = 1'b0;
    set_cfg(1'b1, 1'b0);
    host_wr = 1'b1; ram_sel = 1'b0;
    #1;
    chk("R10 off-RAM we", {14'b0, ram_we_even, ram_we_odd}, 16'h0000);
    chk("R10 off-RAM io16_n", {15'b0, io16_n}, 16'h0001);
    host_wr = 1'b0;

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule